// File: doc/BRIEF.md
# Transmit Clock Loss Monitor with Receive-Timing Fallback

The block watches a transmit clock that arrives from outside the chip. It uses a free-running monitor clock as its timebase. The transmit clock is brought into the monitor domain through a two-flop synchroniser. Each rising edge that the synchroniser sees becomes a one-cycle transmit clock enable. When no rising edge arrives for `LOSS_CYC` monitor cycles, the block declares the transmit clock lost. It raises a live loss flag and sets a sticky status flag, which the host clears.

The loss is always reported. The block acts on it only when the host has set the fallback control input, which is expected to reset to 0. While fallback is enabled and the clock is lost, three things change:
- Transmit timing is taken from the recovered receive clock enable instead of the transmit clock.
- The outgoing data is forced to the alarm indication signal, an all-ones word.
- `sel_rx_o` shows that the substitution is in force.

The loss ends after `REC_EDGES` rising edges, each arriving within `LOSS_CYC` monitor cycles of the previous one. Timing and data then return to normal. Clock switching is modelled as a choice between enables; no clock is gated.

Top module: `txclk_guard`

## Requirements
- R1: After reset, `loss_live_o`, `loss_sticky_o` and `sel_rx_o` are 0.
- R2: With `fallback_en_i` at 0, `tx_data_o` equals `tx_data_i`, `sel_rx_o` is 0 and `clk_en_o` is the transmit edge enable, whether or not a loss is active.
- R3: `loss_live_o` rises once `LOSS_CYC` consecutive monitor cycles pass without a synchronised rising edge of `tx_clk_i`. It does not rise earlier. Synchroniser latency adds up to 3 monitor cycles.
- R4: With `fallback_en_i` at 1 and a loss active, `sel_rx_o` is 1 and `clk_en_o` equals `rx_clk_en_i` in every cycle.
- R5: With `fallback_en_i` at 1 and a loss active, every bit of `tx_data_o` is 1.
- R6: A loss clears after `REC_EDGES` synchronised rising edges, with no gap of `LOSS_CYC` cycles between them. After that, timing and data return to the R2 behaviour.
- R7: `loss_sticky_o` is set one cycle after `loss_live_o` is 1. It stays set until `status_clr_i` is high in a cycle where the live loss is 0. A clear while the loss is live has no effect.
- R8: While the transmit clock runs and no loss is active, `clk_en_o` pulses once for each rising edge of `tx_clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running monitor clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_clk_i | input | 1 | Transmit clock level, asynchronous to clk_i |
| rx_clk_en_i | input | 1 | Recovered receive clock enable, one cycle per bit |
| fallback_en_i | input | 1 | Enables clock substitution and alarm data on loss |
| status_clr_i | input | 1 | Clears the sticky loss flag |
| tx_data_i | input | DATA_W | Transmit data from the framer |
| loss_live_o | output | 1 | Live loss-of-transmit-clock indication |
| loss_sticky_o | output | 1 | Latched loss status |
| sel_rx_o | output | 1 | Receive timing is in use |
| clk_en_o | output | 1 | Selected transmit timing enable |
| tx_data_o | output | DATA_W | Transmit data, or all ones during fallback |

## Verification
The assertions take three things for granted about the inputs:
- `fallback_en_i`, `status_clr_i`, `rx_clk_en_i` and `tx_data_i` change only in the monitor clock domain.
- Each high or low phase of `tx_clk_i` lasts at least two monitor cycles, so the synchroniser misses no edge.
- The rising-edge spacing stays well under `LOSS_CYC` whenever the clock is meant to be running.

The stimulus drives every input on the falling edge of the monitor clock. It runs the transmit clock with half periods of two or three monitor cycles, and stops it outright to create a loss. Data, receive enables and the fallback bit are randomised only inside phases where the loss state is known.

// File: rtl/txg_pkg.sv
`timescale 1ns/1ps
package txg_pkg;
  typedef enum logic {
    TXG_RUN  = 1'b0,
    TXG_LOST = 1'b1
  } txg_state_e;
endpackage

// File: rtl/txg_edge_sync.sv
`timescale 1ns/1ps
module txg_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/txg_loss_mon.sv
`timescale 1ns/1ps
module txg_loss_mon
  import txg_pkg::*;
#(
  parameter int unsigned LOSS_CYC  = 64,
  parameter int unsigned REC_EDGES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic loss_o
);
  localparam int unsigned IDLE_W = $clog2(LOSS_CYC + 1);
  localparam int unsigned REC_W  = $clog2(REC_EDGES + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX  = IDLE_W'(LOSS_CYC);
  localparam logic [IDLE_W-1:0] IDLE_TRIP = IDLE_W'(LOSS_CYC - 1);
  localparam logic [REC_W-1:0]  REC_LAST  = REC_W'(REC_EDGES - 1);

  logic [IDLE_W-1:0] idle_q;
  logic [REC_W-1:0]  rec_q;
  txg_state_e        state_q;
  logic              timeout;

  assign timeout = !edge_i && (idle_q == IDLE_TRIP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
    end else if (edge_i) begin
      idle_q <= '0;
    end else if (idle_q != IDLE_MAX) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TXG_RUN;
      rec_q   <= '0;
    end else begin
      unique case (state_q)
        TXG_RUN: begin
          rec_q <= '0;
          if (timeout) state_q <= TXG_LOST;
        end
        TXG_LOST: begin
          if (edge_i) begin
            if (rec_q == REC_LAST) begin
              state_q <= TXG_RUN;
              rec_q   <= '0;
            end else begin
              rec_q <= rec_q + 1'b1;
            end
          end else if (timeout) begin
            rec_q <= '0;  // gap too long, recovery restarts
          end
        end
        default: state_q <= TXG_RUN;
      endcase
    end
  end

  assign loss_o = (state_q == TXG_LOST);
endmodule

// File: rtl/txg_fallback_mux.sv
`timescale 1ns/1ps
module txg_fallback_mux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              loss_i,
  input  logic              tx_edge_i,
  input  logic              rx_clk_en_i,
  input  logic              fallback_en_i,
  input  logic              status_clr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              sticky_o,
  output logic              sel_rx_o,
  output logic              clk_en_o,
  output logic [DATA_W-1:0] tx_data_o
);
  localparam logic [DATA_W-1:0] AIS_WORD = '1;

  logic sticky_q;
  logic use_rx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= 1'b0;
    else         sticky_q <= loss_i | (sticky_q & ~status_clr_i);
  end

  assign use_rx    = loss_i & fallback_en_i;
  assign sticky_o  = sticky_q;
  assign sel_rx_o  = use_rx;
  assign clk_en_o  = use_rx ? rx_clk_en_i : tx_edge_i;
  assign tx_data_o = use_rx ? AIS_WORD : tx_data_i;
endmodule

// File: rtl/txclk_guard.sv
`timescale 1ns/1ps
module txclk_guard #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned LOSS_CYC    = 64,
  parameter int unsigned REC_EDGES   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_clk_i,
  input  logic              rx_clk_en_i,
  input  logic              fallback_en_i,
  input  logic              status_clr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              loss_live_o,
  output logic              loss_sticky_o,
  output logic              sel_rx_o,
  output logic              clk_en_o,
  output logic [DATA_W-1:0] tx_data_o
);
  logic tx_edge;
  logic loss;

  txg_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(tx_clk_i),
    .rise_o (tx_edge)
  );

  txg_loss_mon #(.LOSS_CYC(LOSS_CYC), .REC_EDGES(REC_EDGES)) i_mon (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .edge_i(tx_edge),
    .loss_o(loss)
  );

  txg_fallback_mux #(.DATA_W(DATA_W)) i_mux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .loss_i       (loss),
    .tx_edge_i    (tx_edge),
    .rx_clk_en_i  (rx_clk_en_i),
    .fallback_en_i(fallback_en_i),
    .status_clr_i (status_clr_i),
    .tx_data_i    (tx_data_i),
    .sticky_o     (loss_sticky_o),
    .sel_rx_o     (sel_rx_o),
    .clk_en_o     (clk_en_o),
    .tx_data_o    (tx_data_o)
  );

  assign loss_live_o = loss;
endmodule

// File: rtl/txclk_guard_chk.sv
`timescale 1ns/1ps
module txclk_guard_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LOSS_CYC = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_edge,
  input logic              rx_clk_en_i,
  input logic              fallback_en_i,
  input logic              status_clr_i,
  input logic [DATA_W-1:0] tx_data_i,
  input logic              loss_live_o,
  input logic              loss_sticky_o,
  input logic              sel_rx_o,
  input logic              clk_en_o,
  input logic [DATA_W-1:0] tx_data_o
);
  localparam int unsigned GAP_W = $clog2(LOSS_CYC + 1);
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      gap_q <= '0;
    else if (tx_edge)                 gap_q <= '0;
    else if (gap_q != GAP_W'(LOSS_CYC)) gap_q <= gap_q + 1'b1;
  end

  always_comb begin
    if (!rst_ni) assert_reset_R1: assert (!loss_live_o && !loss_sticky_o && !sel_rx_o);
  end

  assert_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fallback_en_i |-> (tx_data_o == tx_data_i) && !sel_rx_o && (clk_en_o == tx_edge));

  assert_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loss_live_o) |-> (gap_q >= GAP_W'(LOSS_CYC - 1)));

  assert_rxtime_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loss_live_o && fallback_en_i) |-> sel_rx_o && (clk_en_o == rx_clk_en_i));

  assert_ais_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loss_live_o && fallback_en_i) |-> (tx_data_o == '1));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(loss_live_o) |-> $past(tx_edge));

  assert_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loss_live_o |=> loss_sticky_o);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loss_sticky_o && !status_clr_i) |=> loss_sticky_o);
endmodule

bind txclk_guard txclk_guard_chk #(.DATA_W(DATA_W), .LOSS_CYC(LOSS_CYC)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_edge      (tx_edge),
  .rx_clk_en_i  (rx_clk_en_i),
  .fallback_en_i(fallback_en_i),
  .status_clr_i (status_clr_i),
  .tx_data_i    (tx_data_i),
  .loss_live_o  (loss_live_o),
  .loss_sticky_o(loss_sticky_o),
  .sel_rx_o     (sel_rx_o),
  .clk_en_o     (clk_en_o),
  .tx_data_o    (tx_data_o)
);

// File: tb/test_txclk_guard.sv
`timescale 1ns/1ps
module test_txclk_guard;
  localparam int DATA_W    = 8;
  localparam int LOSS_CYC  = 64;
  localparam int REC_EDGES = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tx_clk_i = 1'b0;
  logic              rx_clk_en_i = 1'b0;
  logic              fallback_en_i = 1'b0;
  logic              status_clr_i = 1'b0;
  logic [DATA_W-1:0] tx_data_i = '0;
  logic              loss_live_o, loss_sticky_o, sel_rx_o, clk_en_o;
  logic [DATA_W-1:0] tx_data_o;

  int  errors = 0;
  int  checks = 0;
  int  cyc = 0;
  int  rise_cnt = 0;
  int  last_rise = 0;
  int  tx_half = 2;
  bit  tx_run = 1'b0;
  bit  done = 1'b0;
  int  seed_dummy;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  txclk_guard #(.DATA_W(DATA_W), .LOSS_CYC(LOSS_CYC), .REC_EDGES(REC_EDGES)) i_txclk_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_clk_i(tx_clk_i), .rx_clk_en_i(rx_clk_en_i),
    .fallback_en_i(fallback_en_i), .status_clr_i(status_clr_i), .tx_data_i(tx_data_i),
    .loss_live_o(loss_live_o), .loss_sticky_o(loss_sticky_o), .sel_rx_o(sel_rx_o),
    .clk_en_o(clk_en_o), .tx_data_o(tx_data_o)
  );

  // transmit clock generator
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk_i);
      if (tx_run) begin
        if (ph >= tx_half - 1) begin
          ph = 0;
          tx_clk_i = ~tx_clk_i;
          if (tx_clk_i) begin
            rise_cnt++;
            last_rise = cyc;
          end
        end else ph++;
      end
    end
  end

  function automatic logic [DATA_W-1:0] exp_data(bit fb, bit lost, logic [DATA_W-1:0] d);
    return (fb && lost) ? '1 : d;
  endfunction

  function automatic bit exp_clken(bit fb, bit lost, bit rx_en, bit tx_en);
    return (fb && lost) ? rx_en : tx_en;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic wait_until_cyc(int c);
    while (cyc < c) step();
  endtask

  task automatic wait_rises(int n);
    while (rise_cnt < n) step();
  endtask

  task automatic rand_phase(int n, bit lost, bit fb_rand, bit tx_stopped, string req);
    for (int i = 0; i < n; i++) begin
      bit fb;
      step();
      fb = fb_rand ? bit'($urandom_range(0, 1)) : fallback_en_i;
      fallback_en_i = fb;
      rx_clk_en_i   = $urandom_range(0, 1);
      tx_data_i     = DATA_W'($urandom);
      #0.5;
      check(tx_data_o == exp_data(fb, lost, tx_data_i), req, tx_data_o, exp_data(fb, lost, tx_data_i));
      check(sel_rx_o == (fb && lost), req, sel_rx_o, fb && lost);
      if (fb && lost || tx_stopped)
        check(clk_en_o == exp_clken(fb, lost, rx_clk_en_i, 1'b0), req, clk_en_o,
              exp_clken(fb, lost, rx_clk_en_i, 1'b0));
    end
  endtask

  initial begin
    int p, edges, pulses, stop_ref;
    seed_dummy = $urandom(32'h1c3a5);
    // R1 reset state
    repeat (3) step();
    check(!loss_live_o && !loss_sticky_o && !sel_rx_o, "R1", {loss_live_o, loss_sticky_o, sel_rx_o}, 0);
    rst_ni = 1'b1;
    tx_half = 2;
    tx_run = 1'b1;
    repeat (20) step();
    check(!loss_live_o, "R1", loss_live_o, 0);

    // R2 running clock, random fallback, no loss
    rand_phase(150, 1'b0, 1'b1, 1'b0, "R2");
    fallback_en_i = 1'b0;

    // R8 edge enable count with half period 3
    tx_half = 3;
    repeat (10) step();
    p = rise_cnt; pulses = 0;
    for (int i = 0; i < 300; i++) begin
      step();
      if (clk_en_o) pulses++;
    end
    edges = rise_cnt - p;
    check((pulses >= edges - 1) && (pulses <= edges + 1), "R8", pulses, edges);
    tx_half = 2;

    // R3 stop clock, loss not before LOSS_CYC, declared after
    tx_run = 1'b0;
    stop_ref = last_rise;
    wait_until_cyc(stop_ref + LOSS_CYC - 2);
    check(!loss_live_o, "R3 early", loss_live_o, 0);
    wait_until_cyc(stop_ref + LOSS_CYC + 8);
    check(loss_live_o, "R3 declared", loss_live_o, 1);
    step();
    check(loss_sticky_o, "R7 set", loss_sticky_o, 1);

    // R7 clear while live ignored
    status_clr_i = 1'b1; step(); status_clr_i = 1'b0;
    repeat (2) step();
    check(loss_sticky_o, "R7 clear while live", loss_sticky_o, 1);

    // R2 loss without fallback: data passes, no tx enables
    rand_phase(100, 1'b1, 1'b0, 1'b1, "R2 loss");

    // R4 and R5 loss with fallback
    fallback_en_i = 1'b1;
    rand_phase(150, 1'b1, 1'b0, 1'b1, "R4/R5");
    rand_phase(100, 1'b1, 1'b1, 1'b1, "R5 mixed");
    fallback_en_i = 1'b1;

    // R6 recovery: too few edges then enough
    p = rise_cnt;
    tx_run = 1'b1;
    wait_rises(p + REC_EDGES - 1);
    step(); step();
    check(loss_live_o, "R6 not yet", loss_live_o, 1);
    wait_rises(p + REC_EDGES + 1);
    repeat (3) step();
    check(!loss_live_o, "R6 cleared", loss_live_o, 0);
    tx_data_i = 8'h5a; #0.5;
    check(tx_data_o == 8'h5a && !sel_rx_o, "R6 data back", tx_data_o, 8'h5a);
    check(loss_sticky_o, "R7 kept", loss_sticky_o, 1);

    // R7 clear after loss gone
    step(); status_clr_i = 1'b1; step(); status_clr_i = 1'b0;
    step();
    check(!loss_sticky_o, "R7 cleared", loss_sticky_o, 0);

    // R6 back to normal under random traffic
    rand_phase(100, 1'b0, 1'b1, 1'b0, "R6 normal");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule